// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a target on a two-wire serial bus that sits in front of an on-chip byte-addressed memory array. It samples the bus clock and data lines in the system clock domain and finds start and stop conditions. It answers to a seven-bit device address made of the fixed prefix `1010` and three strap inputs. A host writes a two-byte word address and then data, or reads back data from the internal address counter, one byte at a time or as a continuous stream.

Incoming write data is collected in a page buffer. The buffer is committed to the array only when the host ends the write with a stop. A self-timed write cycle then runs for a parameterised number of system clocks and is shown on `busy_o`. While that cycle runs the target acknowledges nothing, so a host can poll until the target answers again. A write-protect input blocks every commit. The data line is modelled as an open-drain pull-down enable: `sda_oe_o` high means the target pulls the line low.

Top module: `eep_twowire_target`

## Requirements
- R1: A falling data line while the bus clock is high (start) begins a new transfer from any state. A rising data line while the bus clock is high (stop) returns the target to idle.
- R2: The first byte after a start is compared MSB first as `1010`, then `strap_i[2:0]`, then the direction bit (1 = read). On a mismatch the target gives no acknowledge and ignores all bytes until the next start.
- R3: Every byte the target accepts is acknowledged: the device byte, both word-address bytes and each data byte. The target acknowledges by pulling the line low for the ninth clock.
- R4: A write sends the word-address high byte and then the low byte. The low log2(MEM_BYTES) bits select the location. The data bytes become readable after the stop that ends the sequence.
- R5: During a write only the low log2(PAGE_BYTES) address bits advance. Past the end of a page the address returns to the start of the same page, and later bytes overwrite earlier ones.
- R6: A stop that commits data starts a write cycle. `busy_o` is high for exactly WRITE_CLKS system clocks. During that time not even a matching device byte is acknowledged.
- R7: When `wp_i` is high at the stop, nothing is committed and no write cycle starts. The bytes are still acknowledged.
- R8: The address counter holds the last accessed address plus one, and a read with no word address returns the byte there.
- R9: A read keeps sending bytes while the host acknowledges each one. The address counter wraps from the last array location to 0.
- R10: A write sequence cut off by a repeated start commits nothing. Its word address still loads the counter, which gives a random read.
- R11: After reset the line is released and `busy_o` is low. `sda_oe_o` changes only after a bus clock falling edge, never while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low |
| strap_i | input | 3 | Device address strap bits |
| wp_i | input | 1 | High blocks all commits to the array |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The bench writes more than a page so the address wraps inside the page. A design that carried into the page bits would corrupt the next page, and the bench reads that byte back. It reads across a page boundary and across the top of the array, where a design that used the write wrap for reads would return the wrong byte. It probes the target during a write cycle and after a wrong strap, where an acknowledge is a failure. It also checks that a write-protected write or an aborted write leaves the old data in place and starts no write cycle.

// File: rtl/eep_pkg.sv
// Shared types for the two-wire EEPROM target.
// Assumes nothing beyond IEEE 1800-2017 packages.
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_ACK,
        ST_RDAT,
        ST_RACK
    } eep_state_t;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/eep_line_sampler.sv
// Brings the bus clock and data lines into the system clock domain and
// flags clock edges, start and stop. Assumes the system clock is much
// faster than the bus clock. Idle bus level is high on both lines.
module eep_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_level,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_pipe;
    logic [2:0] sda_pipe;

    // Two synchronising flops plus one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= 3'b111;
            sda_pipe <= 3'b111;
        end else begin
            scl_pipe <= {scl_pipe[1:0], scl_i};
            sda_pipe <= {sda_pipe[1:0], sda_i};
        end
    end

    assign sda_level = sda_pipe[1];
    assign scl_rise  = scl_pipe[1] & ~scl_pipe[2];
    assign scl_fall  = ~scl_pipe[1] & scl_pipe[2];
    assign start_det = scl_pipe[1] & scl_pipe[2] & sda_pipe[2] & ~sda_pipe[1];
    assign stop_det  = scl_pipe[1] & scl_pipe[2] & ~sda_pipe[2] & sda_pipe[1];
endmodule

// File: rtl/eep_write_timer.sv
// Models the self-timed write cycle: a kick loads a down-counter and busy
// stays high until it reaches zero. Assumes WRITE_CLKS >= 1.
module eep_write_timer #(
    parameter int WRITE_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(WRITE_CLKS + 1);

    logic [CW-1:0] remain;

    // Load on kick, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (kick) begin
            remain <= CW'(WRITE_CLKS);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/eep_twowire_target.sv
// Two-wire bus EEPROM target over an on-chip byte array. Decodes the
// device byte, two word-address bytes, writes through a page buffer that
// is committed at stop, and streams reads from an address counter.
// Assumes MEM_BYTES and PAGE_BYTES are powers of two, PAGE_BYTES <
// MEM_BYTES <= 65536, and the system clock far above the bus clock.
module eep_twowire_target
    import eep_pkg::*;
#(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 128,
    parameter int WRITE_CLKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       busy_o
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic sda_level, scl_rise, scl_fall, start_det, stop_det;
    logic busy, commit_now, data_take;

    eep_state_t           state, ack_next;
    logic [3:0]           bit_cnt;
    logic [7:0]           rx_sh, tx_sh, hi_byte, rd_byte;
    logic [ADDR_W-1:0]    addr;
    logic                 hack, sda_oe;
    logic [PAGE_BYTES-1:0] page_vld;
    logic [15:0]          word_addr;
    logic [7:0]           page_buf [PAGE_BYTES];
    logic [7:0]           mem      [MEM_BYTES];

    eep_line_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_level (sda_level),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_write_timer #(.WRITE_CLKS(WRITE_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (commit_now),
        .busy  (busy)
    );

    assign commit_now = stop_det && (|page_vld) && !wp_i;
    assign data_take  = (state == ST_WDAT) && scl_fall && (bit_cnt == 4'd8)
                        && !start_det && !stop_det;
    assign word_addr  = {hi_byte, rx_sh};
    assign rd_byte    = mem[addr];

    // Page buffer capture and stop-time commit of all buffered bytes.
    always_ff @(posedge clk) begin
        if (data_take) begin
            page_buf[addr[PAGE_W-1:0]] <= rx_sh;
        end
        if (commit_now) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (page_vld[i]) begin
                    mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= page_buf[i];
                end
            end
        end
    end

    // Bus protocol sequencer: receive, acknowledge, transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ack_next <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            hi_byte  <= '0;
            addr     <= '0;
            hack     <= 1'b0;
            sda_oe   <= 1'b0;
            page_vld <= '0;
        end else if (start_det) begin
            state    <= ST_DEV;
            bit_cnt  <= '0;
            sda_oe   <= 1'b0;
            page_vld <= '0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            page_vld <= '0;
        end else begin
            case (state)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        rx_sh   <= {rx_sh[6:0], sda_level};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b1;
                        state   <= ST_ACK;
                        case (state)
                            ST_DEV: begin
                                if (rx_sh[7:4] == DEV_PREFIX && rx_sh[3:1] == strap_i && !busy) begin
                                    ack_next <= rx_sh[0] ? ST_RDAT : ST_AHI;
                                end else begin
                                    sda_oe <= 1'b0;
                                    state  <= ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                hi_byte  <= rx_sh;
                                ack_next <= ST_ALO;
                            end
                            ST_ALO: begin
                                addr     <= word_addr[ADDR_W-1:0];
                                ack_next <= ST_WDAT;
                            end
                            default: begin
                                page_vld[addr[PAGE_W-1:0]] <= 1'b1;
                                addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                                ack_next <= ST_WDAT;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (ack_next == ST_RDAT) begin
                            tx_sh   <= {rd_byte[6:0], 1'b0};
                            sda_oe  <= ~rd_byte[7];
                            addr    <= addr + 1'b1;
                            bit_cnt <= 4'd1;
                        end else begin
                            sda_oe  <= 1'b0;
                        end
                        state <= ack_next;
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            hack   <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            sda_oe  <= ~tx_sh[7];
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        hack <= ~sda_level;
                    end else if (scl_fall) begin
                        if (hack) begin
                            tx_sh   <= {rd_byte[6:0], 1'b0};
                            sda_oe  <= ~rd_byte[7];
                            addr    <= addr + 1'b1;
                            bit_cnt <= 4'd1;
                            state   <= ST_RDAT;
                        end else begin
                            state   <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = sda_oe;
    assign busy_o   = busy;
endmodule

// File: rtl/eep_target_checker.sv
// Protocol properties of the two-wire EEPROM target, bound to its top.
// Assumes the widths passed in match the bound instance.
module eep_target_checker
    import eep_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_fall,
    input logic              stop_det,
    input logic              busy,
    input logic              wp,
    input eep_state_t        state,
    input logic [ADDR_W-1:0] addr
);
    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall)); // R11

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && $past(state) == ST_DEV) |-> !$past(busy)); // R6

    AST_CYCLE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det)); // R4

    AST_PROTECTED_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp)); // R7

    AST_PAGE_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDAT && $past(state) == ST_WDAT)
        |-> (($past(addr) >> PAGE_W) == (addr >> PAGE_W))); // R5
endmodule

bind eep_twowire_target eep_target_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .scl_fall (scl_fall),
    .stop_det (stop_det),
    .busy     (busy),
    .wp       (wp_i),
    .state    (state),
    .addr     (addr)
);

// File: tb/test_eep_twowire_target.sv
`timescale 1ns/1ps
module test_eep_twowire_target;
    localparam int MEMB = 1024;
    localparam int PAGEB = 128;
    localparam int WCLK = 400;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       host_scl = 1'b1;
    logic       host_sda = 1'b1;
    logic       wp = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       sda_oe, busy;
    wire        sda_line = host_sda & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int model [MEMB];
    int cur = 0;
    int bcnt = 0;
    int hi_cnt = 0;
    int oe_viol = 0;
    logic prev_oe = 1'b0;

    eep_twowire_target #(.MEM_BYTES(MEMB), .PAGE_BYTES(PAGEB), .WRITE_CLKS(WCLK)) i_eep_twowire_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (host_scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .strap_i  (strap),
        .wp_i     (wp),
        .busy_o   (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Per-clock monitors: write-cycle length and line stability while SCL high.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) bcnt++;
            else if (bcnt != 0) begin
                chk(bcnt == WCLK, "R6 busy length", bcnt, WCLK);
                bcnt = 0;
            end
            if (host_scl) hi_cnt++; else hi_cnt = 0;
            if (hi_cnt > 4 && sda_oe != prev_oe) begin
                oe_viol++;
                $display("FAIL R11 line changed with SCL high actual=%0d expected=%0d", sda_oe, prev_oe);
            end
            prev_oe = sda_oe;
        end
    end

    task automatic bit_io(input logic v, output logic s);
        wclk(4);
        host_sda = v;
        wclk(4);
        host_scl = 1'b1;
        wclk(5);
        s = sda_line;
        wclk(3);
        host_scl = 1'b0;
    endtask

    task automatic bus_start();
        host_sda = 1'b1;
        wclk(8);
        host_scl = 1'b1;
        wclk(8);
        host_sda = 1'b0;
        wclk(8);
        host_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(4);
        host_sda = 1'b0;
        wclk(4);
        host_scl = 1'b1;
        wclk(8);
        host_sda = 1'b1;
        wclk(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        acked = (s == 1'b0);
    endtask

    task automatic recv_byte(input bit host_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, s);
            b = {b[6:0], s};
        end
        bit_io(host_ack ? 1'b0 : 1'b1, s);
    endtask

    function automatic logic [7:0] dev_byte(input logic [2:0] st, input bit rd);
        return {4'b1010, st, rd};
    endfunction

    // Address phase: device byte (write) plus two word-address bytes.
    task automatic addr_phase(input int a);
        bit ack;
        bus_start();
        send_byte(dev_byte(strap, 1'b0), ack);
        chk(ack, "R2 device ack", ack, 1);
        send_byte(8'((a >> 8) & 255), ack);
        chk(ack, "R3 high address ack", ack, 1);
        send_byte(8'(a & 255), ack);
        chk(ack, "R3 low address ack", ack, 1);
        cur = a % MEMB;
    endtask

    task automatic wr_seq(input int a, input int n, input int base, input bit wait_done, input string req);
        bit ack;
        int page, low;
        addr_phase(a);
        page = (a % MEMB) & ~(PAGEB - 1);
        low = a & (PAGEB - 1);
        for (int i = 0; i < n; i++) begin
            send_byte(8'((base + i) & 255), ack);
            chk(ack, req, ack, 1);
            if (!wp) model[page | ((low + i) % PAGEB)] = (base + i) & 255;
        end
        cur = page | ((low + n) % PAGEB);
        bus_stop();
        if (!wp && n > 0) begin
            wclk(4);
            chk(busy == 1'b1, "R6 busy after stop", busy, 1);
            if (wait_done) while (busy) wclk(1);
        end
    endtask

    task automatic read_stream(input int n, input string req);
        bit ack;
        logic [7:0] b;
        send_byte(dev_byte(strap, 1'b1), ack);
        chk(ack, "R2 read device ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk(b == 8'(model[cur]), req, b, model[cur]);
            cur = (cur + 1) % MEMB;
        end
        bus_stop();
    endtask

    task automatic rand_read(input int a, input int n, input string req);
        addr_phase(a);
        bus_start();
        read_stream(n, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        wclk(6);
        rst_n = 1'b1;
        wclk(3);
        chk(busy == 1'b0, "R11 reset busy", busy, 0);
        chk(sda_oe == 1'b0, "R11 reset line released", sda_oe, 0);

        // R4 byte/page write, then probe during the write cycle (R6).
        wr_seq(16'h0123, 4, 8'h10, 1'b0, "R3 data ack");
        bus_start();
        send_byte(dev_byte(strap, 1'b0), ack);
        chk(!ack, "R6 no ack while busy", ack, 0);
        bus_stop();
        while (busy) wclk(1);

        // R10 random read, R9 sequential, then R8 current-address read.
        rand_read(16'h0123, 3, "R4 readback");
        bus_start();
        read_stream(1, "R8 current address");

        // R2 strap mismatch: no ack, later byte ignored.
        bus_start();
        send_byte(dev_byte(strap ^ 3'b001, 1'b0), ack);
        chk(!ack, "R2 mismatch no ack", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R2 bytes ignored", ack, 0);
        bus_stop();
        wclk(8);
        chk(busy == 1'b0, "R2 no write cycle", busy, 0);

        // R5 page wrap, R9 read crosses page boundary.
        wr_seq(16'h0180, 1, 8'h5A, 1'b1, "R3 data ack");
        wr_seq(16'h017E, 130, 8'h80, 1'b1, "R5 data ack");
        rand_read(16'h017E, 3, "R5 wrap and read cross");
        rand_read(16'h0100, 2, "R5 page start overwritten");

        // R7 write protect.
        wp = 1'b1;
        wr_seq(16'h0123, 1, 8'hEE, 1'b0, "R7 protected ack");
        wclk(20);
        chk(busy == 1'b0, "R7 no write cycle", busy, 0);
        wp = 1'b0;
        rand_read(16'h0123, 1, "R7 data kept");

        // R10 write cut off by repeated start.
        addr_phase(16'h0124);
        send_byte(8'h77, ack);
        chk(ack, "R3 data ack", ack, 1);
        cur = 16'h0125;
        bus_start();
        read_stream(1, "R10 counter after aborted write");
        wclk(8);
        chk(busy == 1'b0, "R10 no write cycle", busy, 0);
        rand_read(16'h0124, 1, "R10 data kept");

        // R9 read wraps top of array to 0; R1 stop/start between sequences.
        wr_seq(MEMB - 1, 1, 8'h3C, 1'b1, "R3 data ack");
        wr_seq(0, 1, 8'hC3, 1'b1, "R3 data ack");
        rand_read(MEMB - 1, 2, "R9 array wrap");
        chk(cur == 1, "R1 sequence count", cur, 1);

        wclk(10);
        chk(oe_viol == 0, "R11 line stable while SCL high", oe_viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule